// File: doc/BRIEF.md
# Block-Granular Security Transaction Filter

This block sits between an upstream bus master and a downstream memory and checks every transaction against a per-block security table. The protected region is split into fixed-size blocks of `2**BLK_SHIFT` bytes. Each block owns one bit in an external table of 32-bit words. A bit of 1 marks the block as non-secure memory and a bit of 0 marks it as secure memory. A transaction passes only when its security attribute matches the block's bit.

A request is accepted into a single stage register. At the same time the table word that covers its block is read from an external synchronous table port. In the following cycle the decision is made. A passing request is issued downstream with its address, direction and size unchanged. A failing request is never issued downstream. Instead it is completed locally with all-zero read data and either an OK or an error response, as chosen by a control input. The first failure seen while the external interrupt status is clear loads the fault details through a capture strobe. That strobe also tells the surrounding register file to set the status. Later failures are still blocked but leave the captured details alone until software clears the status.

The register file, the interrupt output and the table storage all live outside this block. The filter only reads the table and drives the capture strobe.

Top module: `sec_filter`

## Requirements
- R1: For an in-range request, the table word index read is `addr >> (BLK_SHIFT+5)`, and the bit used within that word is `addr[BLK_SHIFT+4:BLK_SHIFT]`, that is, block number modulo 32.
- R2: A table bit of 1 passes only non-secure requests, and a table bit of 0 passes only secure requests.
- R3: A request with `req_unspec`=1 is treated as secure whatever `req_secure` says. With all-zero table words, every such request passes.
- R4: A blocked request never raises `dn_req_valid`. It completes with `blk_rsp_valid`=1 and `blk_rdata` all zero. Writes and reads of any size from 1 to 8 bytes are treated alike.
- R5: For an in-range blocked request, `blk_rsp_err` equals `err_resp_en` (1 means bus error, 0 means OK).
- R6: An in-range blocked request seen while `irq_status`=0 pulses `cap_we` for one cycle. On that strobe, `cap_info1` is the full request address and `cap_info2` is `{14'b0, table_bit, ~req_secure, req_master[15:0]}`, with the master ID in bits 15:0, the inverted secure flag in bit 16 and the table bit in bit 17. The strobe also means "set the status".
- R7: While `irq_status`=1, a blocked request is still blocked but `cap_we` stays 0.
- R8: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. Its decision is presented in the next cycle. While that decision is presented, `req_ready` is 0.
- R9: A request with address at or above `REGION_BYTES` does not read the table (`lut_ren`=0). It is blocked with `blk_rsp_err`=1 regardless of `err_resp_en`, and it never pulses `cap_we`.
- R10: A passing request drives `dn_addr`, `dn_write` and `dn_size` equal to the accepted request's address, direction and size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Upstream request present |
| req_ready | output | 1 | Filter can accept a request this cycle |
| req_addr | input | ADDR_W | Request byte address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_size | input | 3 | Access bytes minus one (1 to 8 bytes) |
| req_secure | input | 1 | Request is secure |
| req_unspec | input | 1 | Security attribute unspecified (treated as secure) |
| req_master | input | 16 | Requester ID |
| lut_ren | output | 1 | Table read enable |
| lut_raddr | output | WIDX_W | Table word index |
| lut_rdata | input | 32 | Table word, valid the cycle after `lut_ren` |
| err_resp_en | input | 1 | Blocked accesses respond with bus error |
| irq_status | input | 1 | Current fault status from the register file |
| dn_req_valid | output | 1 | Downstream request issued |
| dn_addr | output | ADDR_W | Downstream address |
| dn_write | output | 1 | Downstream direction |
| dn_size | output | 3 | Downstream size |
| blk_rsp_valid | output | 1 | Local completion of a blocked request |
| blk_rsp_err | output | 1 | Blocked completion is a bus error |
| blk_rdata | output | DATA_W | Read data for blocked completion |
| cap_we | output | 1 | Load fault info and set status |
| cap_info1 | output | ADDR_W | Faulting address |
| cap_info2 | output | 32 | Master ID, inverted secure flag, table bit |

## Verification
The main sweep runs every block of the region under three table patterns: all zeros, all ones and a mixed pattern. Each block is driven with secure, non-secure and unspecified-attribute requests. The all-zero and all-ones tables show whether the pass rule is inverted. The mixed pattern shows whether the word index and bit index are taken from the right address bits. Unspecified requests with `req_secure`=0 show apart "treated as secure" from "use the raw secure flag". This matters both for the pass decision and for the inverted flag in bit 16 of the captured info. The response control, the status input and the read/write direction are varied with the block number. This separates error from OK responses and capture from suppression. Separate out-of-range requests check that a table lookup never happens for addresses past the region, even with the response control cleared.

// File: rtl/sec_filter_pkg.sv
// Shared constants and helpers for the security transaction filter.
// Assumes requester IDs are 16 bits and the fault-info word is 32 bits.
package sec_filter_pkg;
    localparam int MASTER_W = 16;
    localparam int INFO2_W  = 32;
    localparam int LUT_W    = 32;

    // Pack the second fault-info word: master ID, inverted secure flag, table bit.
    function automatic logic [INFO2_W-1:0] pack_info2(
        input logic [MASTER_W-1:0] master,
        input logic                secure,
        input logic                cfg_bit
    );
        pack_info2 = {{(INFO2_W-MASTER_W-2){1'b0}}, cfg_bit, ~secure, master};
    endfunction
endpackage

// File: rtl/sfl_index.sv
// Address decode for the filter: range check and table word/bit selection.
// Assumes the region starts at address 0 and has REGION_BYTES bytes.
module sfl_index #(
    parameter int ADDR_W       = 16,
    parameter int BLK_SHIFT    = 5,
    parameter int REGION_BYTES = 4096,
    parameter int WIDX_W       = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_range,
    output logic [WIDX_W-1:0] word_idx,
    output logic [4:0]        bit_idx
);
    localparam logic [ADDR_W:0] REGION_LIM = (ADDR_W+1)'(REGION_BYTES);

    // Split the address into range flag, table word index and bit index.
    always_comb begin
        in_range = ({1'b0, addr} < REGION_LIM);
        word_idx = WIDX_W'(addr >> (BLK_SHIFT + 5));
        bit_idx  = addr[BLK_SHIFT+4:BLK_SHIFT];
    end
endmodule

// File: rtl/sfl_decide.sv
// Pass/block decision for a staged request, using the table word just read.
// Assumes lut_word belongs to the staged request whenever stg_valid is set.
module sfl_decide (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stg_valid,
    input  logic        stg_in_range,
    input  logic [31:0] lut_word,
    input  logic [4:0]  bit_idx,
    input  logic        secure,
    input  logic        unspec,
    input  logic        err_resp_en,
    output logic        fwd,
    output logic        blocked,
    output logic        rsp_err,
    output logic        cfg_bit
);
    logic eff_secure;
    logic allow;

    // Evaluate the security match and form the forward/block outputs.
    always_comb begin
        cfg_bit    = lut_word[bit_idx];
        eff_secure = secure | unspec;
        allow      = stg_in_range & (cfg_bit ? ~eff_secure : eff_secure);
        fwd        = stg_valid & allow;
        blocked    = stg_valid & ~allow;
        rsp_err    = ~stg_in_range | err_resp_en;
    end

    // R4: a staged request is either forwarded or blocked, never both or neither
    assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stg_valid |-> $countones({fwd, blocked}) == 1);
    // R9: out-of-range requests never pass and always report an error
    assert_oor_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stg_valid && !stg_in_range) |-> (blocked && rsp_err));
endmodule

// File: rtl/sfl_capture.sv
// Fault-info capture for the first blocked in-range request while status is clear.
// Assumes the register file sets its status on cap_we and clears it by software.
module sfl_capture
    import sec_filter_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                blocked,
    input  logic                in_range,
    input  logic                irq_status,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [MASTER_W-1:0] master,
    input  logic                secure,
    input  logic                cfg_bit,
    output logic                cap_we,
    output logic [ADDR_W-1:0]   cap_info1,
    output logic [INFO2_W-1:0]  cap_info2
);
    // Raise the strobe only for a fresh in-range fault and present its details.
    always_comb begin
        cap_we    = blocked & in_range & ~irq_status;
        cap_info1 = addr;
        cap_info2 = pack_info2(master, secure, cfg_bit);
    end

    // R7: no capture while a previous fault is still pending
    assert_hold_info_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_status |-> !cap_we);
endmodule

// File: rtl/sec_filter.sv
// Top of the block-granular security filter: one request stage, table read
// issued on acceptance, decision presented the following cycle.
// Assumes a synchronous table port with one cycle of read latency and that
// the downstream side and the blocked response are taken in the cycle shown.
module sec_filter
    import sec_filter_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int BLK_SHIFT    = 5,
    parameter int REGION_BYTES = 4096,
    parameter int DATA_W       = 64,
    parameter int NUM_BLOCKS   = REGION_BYTES >> BLK_SHIFT,
    parameter int NUM_WORDS    = (NUM_BLOCKS + 31) / 32,
    parameter int WIDX_W       = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_write,
    input  logic [2:0]          req_size,
    input  logic                req_secure,
    input  logic                req_unspec,
    input  logic [MASTER_W-1:0] req_master,
    output logic                lut_ren,
    output logic [WIDX_W-1:0]   lut_raddr,
    input  logic [LUT_W-1:0]    lut_rdata,
    input  logic                err_resp_en,
    input  logic                irq_status,
    output logic                dn_req_valid,
    output logic [ADDR_W-1:0]   dn_addr,
    output logic                dn_write,
    output logic [2:0]          dn_size,
    output logic                blk_rsp_valid,
    output logic                blk_rsp_err,
    output logic [DATA_W-1:0]   blk_rdata,
    output logic                cap_we,
    output logic [ADDR_W-1:0]   cap_info1,
    output logic [INFO2_W-1:0]  cap_info2
);
    logic                in_range;
    logic [WIDX_W-1:0]   word_idx;
    logic [4:0]          bit_idx;
    logic                accept;

    logic                s_valid;
    logic [ADDR_W-1:0]   s_addr;
    logic                s_write;
    logic [2:0]          s_size;
    logic                s_secure;
    logic                s_unspec;
    logic [MASTER_W-1:0] s_master;
    logic                s_in_range;
    logic [4:0]          s_bit;
    logic                cfg_bit;

    sfl_index #(
        .ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT),
        .REGION_BYTES(REGION_BYTES), .WIDX_W(WIDX_W)
    ) u_index (
        .addr(req_addr), .in_range(in_range),
        .word_idx(word_idx), .bit_idx(bit_idx)
    );

    // Accept when the stage is empty; read the table only for in-range requests.
    always_comb begin
        req_ready = ~s_valid;
        accept    = req_valid & req_ready;
        lut_ren   = accept & in_range;
        lut_raddr = word_idx;
    end

    // Hold the accepted request for one cycle while the table word returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_valid <= 1'b0;
        end else begin
            s_valid <= accept;
        end
    end

    // Latch the request fields on acceptance.
    always_ff @(posedge clk) begin
        if (accept) begin
            s_addr     <= req_addr;
            s_write    <= req_write;
            s_size     <= req_size;
            s_secure   <= req_secure;
            s_unspec   <= req_unspec;
            s_master   <= req_master;
            s_in_range <= in_range;
            s_bit      <= bit_idx;
        end
    end

    sfl_decide u_decide (
        .clk(clk), .rst_n(rst_n),
        .stg_valid(s_valid), .stg_in_range(s_in_range),
        .lut_word(lut_rdata), .bit_idx(s_bit),
        .secure(s_secure), .unspec(s_unspec), .err_resp_en(err_resp_en),
        .fwd(dn_req_valid), .blocked(blk_rsp_valid),
        .rsp_err(blk_rsp_err), .cfg_bit(cfg_bit)
    );

    sfl_capture #(.ADDR_W(ADDR_W)) u_capture (
        .clk(clk), .rst_n(rst_n),
        .blocked(blk_rsp_valid), .in_range(s_in_range), .irq_status(irq_status),
        .addr(s_addr), .master(s_master), .secure(s_secure), .cfg_bit(cfg_bit),
        .cap_we(cap_we), .cap_info1(cap_info1), .cap_info2(cap_info2)
    );

    // Present the staged request downstream; blocked reads see zero data.
    always_comb begin
        dn_addr   = s_addr;
        dn_write  = s_write;
        dn_size   = s_size;
        blk_rdata = '0;
    end

    // R8: every table read is followed by a decision in the next cycle
    assert_decide_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lut_ren |=> (dn_req_valid || blk_rsp_valid));
    // R8: the filter stalls upstream while a decision is presented
    assert_stall_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid || blk_rsp_valid) |-> !req_ready);
    // R5: in-range blocked responses follow the error-response control
    assert_err_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_rsp_valid && s_in_range) |-> (blk_rsp_err == err_resp_en));
    // R4: nothing is forwarded in a cycle with no staged request
    assert_no_idle_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!accept) |-> !dn_req_valid);
endmodule

// File: tb/tb_sec_filter.sv
`timescale 1ns/1ps
module tb_sec_filter;
    localparam int ADDR_W = 16;
    localparam int BLK_SHIFT = 5;
    localparam int REGION_BYTES = 4096;
    localparam int NBLK = REGION_BYTES >> BLK_SHIFT;
    localparam int NW = (NBLK + 31) / 32;
    localparam int WIDX_W = 2;

    logic clk = 0;
    logic rst_n = 0;
    logic req_valid = 0, req_write = 0, req_secure = 0, req_unspec = 0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [2:0] req_size = '0;
    logic [15:0] req_master = '0;
    logic err_resp_en = 0, irq_status = 0;
    logic [31:0] lut_rdata = '0;
    logic req_ready, lut_ren, dn_req_valid, dn_write, blk_rsp_valid, blk_rsp_err, cap_we;
    logic [WIDX_W-1:0] lut_raddr;
    logic [ADDR_W-1:0] dn_addr, cap_info1;
    logic [2:0] dn_size;
    logic [63:0] blk_rdata;
    logic [31:0] cap_info2;
    logic [31:0] lut_mem [NW];

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    // Table storage model: synchronous read, one cycle latency.
    always @(posedge clk) if (lut_ren) lut_rdata <= lut_mem[lut_raddr];

    sec_filter dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_size(req_size),
        .req_secure(req_secure), .req_unspec(req_unspec), .req_master(req_master),
        .lut_ren(lut_ren), .lut_raddr(lut_raddr), .lut_rdata(lut_rdata),
        .err_resp_en(err_resp_en), .irq_status(irq_status),
        .dn_req_valid(dn_req_valid), .dn_addr(dn_addr), .dn_write(dn_write),
        .dn_size(dn_size), .blk_rsp_valid(blk_rsp_valid), .blk_rsp_err(blk_rsp_err),
        .blk_rdata(blk_rdata), .cap_we(cap_we), .cap_info1(cap_info1),
        .cap_info2(cap_info2)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One transaction: drive at a falling edge, accept at the next rising edge,
    // check the decision at the following falling edge.
    task automatic txn(input logic [ADDR_W-1:0] a, input logic wr, input logic sec,
                       input logic uns, input logic [15:0] mst, input logic [2:0] sz,
                       input logic erren, input logic st);
        logic inr, bitv, effs, pass;
        int blk;
        @(negedge clk);
        req_valid = 1; req_addr = a; req_write = wr; req_secure = sec;
        req_unspec = uns; req_master = mst; req_size = sz;
        err_resp_en = erren; irq_status = st;
        inr = (int'(a) < REGION_BYTES);
        blk = int'(a) >> BLK_SHIFT;
        bitv = inr ? lut_mem[blk / 32][blk % 32] : 1'b0;
        effs = sec | uns;
        pass = inr && (bitv ? !effs : effs);
        #1;
        chk("R8 ready before accept", req_ready, 1);
        chk("R9 table read only in range", lut_ren, inr);
        if (inr) chk("R1 table word index", lut_raddr, (blk / 32));
        @(negedge clk);
        req_valid = 0;
        chk("R8 ready low while deciding", req_ready, 0);
        chk("R2 R3 forward decision", dn_req_valid, pass);
        chk("R4 blocked completion", blk_rsp_valid, !pass);
        if (pass) begin
            chk("R10 forwarded addr", dn_addr, a);
            chk("R10 forwarded dir/size", {dn_write, dn_size}, {wr, sz});
        end else begin
            chk("R4 blocked read data zero", blk_rdata, 0);
            chk(inr ? "R5 response select" : "R9 out-of-range error", blk_rsp_err, inr ? erren : 1'b1);
            if (!inr) chk("R9 no capture", cap_we, 0);
            else if (st) chk("R7 no capture while status set", cap_we, 0);
            else begin
                chk("R6 capture strobe", cap_we, 1);
                chk("R6 info1 address", cap_info1, a);
                chk("R6 info2 fields", cap_info2, {14'b0, bitv, ~sec, mst});
            end
        end
    endtask

    initial begin
        for (int w = 0; w < NW; w++) lut_mem[w] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 reset ready", req_ready, 1);
        chk("R4 reset no forward", dn_req_valid, 0);
        chk("R4 reset no block", blk_rsp_valid, 0);
        chk("R6 reset no capture", cap_we, 0);
        rst_n = 1;
        // Main sweep: three table patterns, every block, three attributes.
        for (int p = 0; p < 3; p++) begin
            for (int w = 0; w < NW; w++)
                lut_mem[w] = (p == 0) ? 32'h0 : (p == 1) ? 32'hFFFF_FFFF
                           : (32'h9C3A_65D1 ^ (32'h1111_1111 * w));
            for (int b = 0; b < NBLK; b++) begin
                for (int at = 0; at < 3; at++) begin
                    txn(ADDR_W'(b * 32 + (b * 7 + at) % 32), 1'((b + at) % 2),
                        (at == 0), (at == 2), 16'(b * 257 + at * 31 + p),
                        3'((b + p) % 8), 1'(b % 2), 1'((b % 5) == 3));
                end
            end
        end
        // Out-of-range requests with error control both ways.
        txn(16'h1000, 0, 1, 0, 16'hBEEF, 3'd7, 0, 0);
        txn(16'hFFF8, 1, 0, 0, 16'h1234, 3'd0, 0, 0);
        txn(16'h2345, 0, 0, 1, 16'h0042, 3'd3, 1, 1);
        @(negedge clk);
        chk("R8 idle after sweep", req_ready, 1);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule